// File: doc/BRIEF.md
# Sequential Integer Divider with Condition Flags

This block divides a 32-bit dividend by a 32-bit divisor, one quotient bit per clock, and returns the quotient, the remainder and a small condition-flag vector. Each operation works on unsigned or two's-complement signed operands. A second mode input chooses a long result or a word-size result. The word-size choice changes only the overflow rule: the full quotient is still returned.

The datapath is a radix-2 restoring divider that works on operand magnitudes. Signed operations add one more cycle after the last iteration to apply signs. In that cycle the quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. If the divisor is zero, the block does not run. It raises a one-cycle trap and leaves every result output as it was.

A caller raises a start request while the block is idle. It then waits for the one-cycle completion pulse, and the results are valid from that pulse onwards. Requests that arrive while the block is busy are dropped.

Top module: `div_iter_unit`

## Requirements
- R1: A start with a zero divisor, accepted while idle, raises `dz_trap_o` for exactly one cycle, starting one cycle after the start. Busy stays low. `quot_o`, `rem_o` and `flags_o` keep their previous values.
- R2: Unsigned division gives `quot_o` = floor(dividend/divisor) and `rem_o` = dividend mod divisor. `done_o` rises 32 cycles after the start cycle.
- R3: In unsigned word mode (`word_i`=1, `signed_i`=0), overflow (`flags_o[1]`) is set exactly when the quotient is above 0xFFFF. In long mode (`word_i`=0), overflow is always 0.
- R4: In signed word mode, overflow (`flags_o[1]`) is set exactly when the quotient differs from its own low 16 bits sign-extended to 32 bits.
- R5: The flag vector is `flags_o` = {N, Z, V, C}, with bit 3 = N, bit 2 = Z, bit 1 = V and bit 0 = C. C is always 0. Z is set when the quotient is zero. N is set when the quotient is nonzero and its bit 31 is 1. Z and N are never both set.
- R6: Signed division truncates toward zero, and the remainder carries the sign of the dividend. `done_o` rises 33 cycles after the start cycle.
- R7: In signed mode, 0x80000000 divided by 0xFFFFFFFF returns quotient 0x80000000 and remainder 0, with no trap.
- R8: `done_o` is a single-cycle pulse. `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` rises, and is low in that cycle.
- R9: A start raised while `busy_o` is high is ignored. It causes no trap, no extra completion and no change to the result of the operation in progress.
- R10: A start raised in the cycle where `done_o` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation request, sampled while idle |
| signed_i | input | 1 | 1 = two's-complement operands |
| word_i | input | 1 | 1 = word-size overflow rule |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dz_trap_o | output | 1 | One-cycle divide-by-zero trap |
| quot_o | output | 32 | Quotient of the last completed division |
| rem_o | output | 32 | Remainder of the last completed division |
| flags_o | output | 4 | {N, Z, V, C} of the last completed division |

## Verification
Two functions of this block can land on the same clock edge.

The first case is completion of one division and acceptance of the next start. The bench raises start in the very cycle `done_o` is seen. It then checks that busy is high on the following cycle, that the second result arrives a full latency later, and that the first result held until then.

The second case is a zero-divisor request arriving while an iteration is under way. The bench raises such a request mid-run. It requires that no trap appears and that the running division finishes with its own operands.

// File: rtl/div_iter_pkg.sv
package div_iter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } dstate_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } ccr_t;

endpackage

// File: rtl/div_restore_step.sv
module div_restore_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] part_i,
  input  logic [W-1:0] shreg_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] part_o,
  output logic [W-1:0] shreg_o
);
  logic [W:0] shifted;
  logic [W:0] trial;
  logic       fits;

  always_comb begin
    shifted = {part_i, shreg_i[W-1]};
    trial   = shifted - {1'b0, dvs_i};
    fits    = ~trial[W];
    part_o  = fits ? trial[W-1:0] : shifted[W-1:0];
    shreg_o = {shreg_i[W-2:0], fits};
  end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] mag_quo_i,
  input  logic [W-1:0] mag_rem_i,
  input  logic         neg_quo_i,
  input  logic         neg_rem_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  always_comb begin
    quo_o = neg_quo_i ? (~mag_quo_i + 1'b1) : mag_quo_i;
    rem_o = neg_rem_i ? (~mag_rem_i + 1'b1) : mag_rem_i;
  end
endmodule

// File: rtl/div_flag_gen.sv
module div_flag_gen
  import div_iter_pkg::*;
#(
  parameter int W    = 32,
  parameter int HALF = 16
) (
  input  logic [W-1:0] quo_i,
  input  logic         sgn_i,
  input  logic         word_i,
  output ccr_t         ccr_o
);
  logic [W-1:0] sext_low;
  logic         ovf_s;
  logic         ovf_u;

  always_comb begin
    sext_low    = {{(W-HALF){quo_i[HALF-1]}}, quo_i[HALF-1:0]};
    ovf_s       = (quo_i != sext_low);
    ovf_u       = |quo_i[W-1:HALF];
    ccr_o.carry = 1'b0;
    ccr_o.ovf   = word_i & (sgn_i ? ovf_s : ovf_u);
    ccr_o.zero  = (quo_i == '0);
    ccr_o.neg   = (quo_i != '0) & quo_i[W-1];
  end
endmodule

// File: rtl/div_iter_unit.sv
module div_iter_unit
  import div_iter_pkg::*;
#(
  parameter int W    = 32,
  parameter int HALF = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic         word_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dz_trap_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic [3:0]   flags_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  dstate_e       state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  part_q, part_d;
  logic [W-1:0]  shreg_q, shreg_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic          negq_q, negq_d;
  logic          negr_q, negr_d;
  logic          sgn_q, sgn_d;
  logic          word_q, word_d;
  logic [W-1:0]  quot_q, quot_d;
  logic [W-1:0]  remo_q, remo_d;
  ccr_t          ccr_q, ccr_d;
  logic          done_q, done_d;
  logic          trap_q, trap_d;

  logic [W-1:0]  part_nx, shreg_nx;
  logic [W-1:0]  fix_in_q, fix_in_r;
  logic [W-1:0]  fin_quo, fin_rem;
  ccr_t          fin_ccr;
  logic [W-1:0]  a_mag, b_mag;

  div_restore_step #(.W(W)) u_step (
    .part_i (part_q),
    .shreg_i(shreg_q),
    .dvs_i  (dvs_q),
    .part_o (part_nx),
    .shreg_o(shreg_nx)
  );

  assign fix_in_q = (state_q == ST_FIX) ? shreg_q : shreg_nx;
  assign fix_in_r = (state_q == ST_FIX) ? part_q  : part_nx;

  div_sign_fix #(.W(W)) u_fix (
    .mag_quo_i(fix_in_q),
    .mag_rem_i(fix_in_r),
    .neg_quo_i(negq_q),
    .neg_rem_i(negr_q),
    .quo_o    (fin_quo),
    .rem_o    (fin_rem)
  );

  div_flag_gen #(.W(W), .HALF(HALF)) u_flags (
    .quo_i (fin_quo),
    .sgn_i (sgn_q),
    .word_i(word_q),
    .ccr_o (fin_ccr)
  );

  always_comb begin
    a_mag = (signed_i && dividend_i[W-1]) ? (~dividend_i + 1'b1) : dividend_i;
    b_mag = (signed_i && divisor_i[W-1])  ? (~divisor_i + 1'b1)  : divisor_i;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    part_d  = part_q;
    shreg_d = shreg_q;
    dvs_d   = dvs_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    sgn_d   = sgn_q;
    word_d  = word_q;
    quot_d  = quot_q;
    remo_d  = remo_q;
    ccr_d   = ccr_q;
    done_d  = 1'b0;
    trap_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (divisor_i == '0) begin
            trap_d = 1'b1;
          end else begin
            state_d = ST_RUN;
            cnt_d   = '0;
            part_d  = '0;
            shreg_d = a_mag;
            dvs_d   = b_mag;
            sgn_d   = signed_i;
            word_d  = word_i;
            negq_d  = signed_i & (dividend_i[W-1] ^ divisor_i[W-1]);
            negr_d  = signed_i & dividend_i[W-1];
          end
        end
      end
      ST_RUN: begin
        part_d  = part_nx;
        shreg_d = shreg_nx;
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          if (sgn_q) begin
            state_d = ST_FIX;
          end else begin
            state_d = ST_IDLE;
            quot_d  = fin_quo;
            remo_d  = fin_rem;
            ccr_d   = fin_ccr;
            done_d  = 1'b1;
          end
        end
      end
      ST_FIX: begin
        state_d = ST_IDLE;
        quot_d  = fin_quo;
        remo_d  = fin_rem;
        ccr_d   = fin_ccr;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      part_q  <= '0;
      shreg_q <= '0;
      dvs_q   <= '0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      sgn_q   <= 1'b0;
      word_q  <= 1'b0;
      quot_q  <= '0;
      remo_q  <= '0;
      ccr_q   <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      part_q  <= part_d;
      shreg_q <= shreg_d;
      dvs_q   <= dvs_d;
      negq_q  <= negq_d;
      negr_q  <= negr_d;
      sgn_q   <= sgn_d;
      word_q  <= word_d;
      quot_q  <= quot_d;
      remo_q  <= remo_d;
      ccr_q   <= ccr_d;
      done_q  <= done_d;
      trap_q  <= trap_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign dz_trap_o = trap_q;
  assign quot_o    = quot_q;
  assign rem_o     = remo_q;
  assign flags_o   = ccr_q;

  // R1: a trap leaves every result output untouched and never overlaps a run
  p_trap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(flags_o) && !busy_o));

  // R3: long mode never reports overflow
  p_long_no_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !word_q) |-> !flags_o[1]);

  // R5: zero and negative are exclusive and carry stays clear
  p_zn_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!(flags_o[2] && flags_o[3]) && !flags_o[0]));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: a run ends only with completion
  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> (busy_o || done_o));

  // R9: no trap can arise while a division is in progress
  p_no_trap_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !dz_trap_o);

  // R8: results change only on completion
  p_quot_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(quot_o));
endmodule

// File: tb/div_iter_unit_test.sv
module div_iter_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic        word_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic        busy_o, done_o, dz_trap_o;
  logic [31:0] quot_o, rem_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  div_iter_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .word_i(word_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .dz_trap_o(dz_trap_o),
    .quot_o(quot_o), .rem_o(rem_o), .flags_o(flags_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] b, input bit s, input bit w,
                                output logic [31:0] q, output logic [31:0] r, output logic [3:0] f);
    logic v, z, n;
    if (s) begin
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
        q = 32'h8000_0000; r = 32'h0;
      end else begin
        q = $signed(a) / $signed(b);
        r = $signed(a) % $signed(b);
      end
    end else begin
      q = a / b;
      r = a % b;
    end
    v = w && (s ? (q != {{16{q[15]}}, q[15:0]}) : (q > 32'h0000_FFFF));
    z = (q == 32'h0);
    n = !z && q[31];
    f = {n, z, v, 1'b0};
  endfunction

  task automatic launch(input logic [31:0] a, input logic [31:0] b, input bit s, input bit w);
    dividend_i = a; divisor_i = b; signed_i = s; word_i = w; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done_o && n < 40);
  endtask

  task automatic check_result(input logic [31:0] a, input logic [31:0] b, input bit s, input bit w,
                              input int n, input string tag);
    logic [31:0] eq, er;
    logic [3:0]  ef;
    model(a, b, s, w, eq, er, ef);
    chk(n == (s ? 33 : 32), {tag, " latency"}, 32'(n), s ? 32'd33 : 32'd32);
    chk(quot_o == eq, {tag, " quotient"}, quot_o, eq);
    chk(rem_o == er, {tag, " remainder"}, rem_o, er);
    chk(flags_o == ef, {tag, " flags"}, {28'h0, flags_o}, {28'h0, ef});
    chk(!busy_o, "R8 busy low at done", {31'h0, busy_o}, 32'h0);
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit s, input bit w, input string tag);
    int n;
    @(negedge clk);
    launch(a, b, s, w);
    chk(busy_o, "R8 busy after start", {31'h0, busy_o}, 32'h1);
    wait_done(n);
    check_result(a, b, s, w, n, tag);
    @(negedge clk);
    chk(!done_o, "R8 done single pulse", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_reset();
    chk(quot_o == 0 && rem_o == 0, "reset results", quot_o, 32'h0);
    chk(flags_o == 4'h0, "reset flags", {28'h0, flags_o}, 32'h0);
    chk(!busy_o && !done_o && !dz_trap_o, "reset status",
        {29'h0, busy_o, done_o, dz_trap_o}, 32'h0);
  endtask

  task automatic t_unsigned();
    run_op(32'd100, 32'd7, 1'b0, 1'b0, "R2 100/7");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R5 neg flag unsigned");
    run_op(32'd5, 32'd9, 1'b0, 1'b0, "R5 zero quotient");
    run_op(32'hDEAD_BEEF, 32'h0001_0003, 1'b0, 1'b0, "R2 mixed");
    run_op(32'h1234_5678, 32'h10, 1'b0, 1'b0, "R3 long no ovf");
  endtask

  task automatic t_word_u();
    run_op(32'h1234_5678, 32'h10, 1'b0, 1'b1, "R3 word ovf");
    run_op(32'h0001_FFFE, 32'd2, 1'b0, 1'b1, "R3 word edge 0xFFFF");
    run_op(32'h0002_0000, 32'd2, 1'b0, 1'b1, "R3 word edge 0x10000");
  endtask

  task automatic t_signed();
    run_op(-32'sd7, 32'd2, 1'b1, 1'b0, "R6 -7/2");
    run_op(32'd7, -32'sd2, 1'b1, 1'b0, "R6 7/-2");
    run_op(-32'sd7, -32'sd2, 1'b1, 1'b0, "R6 -7/-2");
    run_op(-32'sd6, 32'd3, 1'b1, 1'b0, "R6 exact");
  endtask

  task automatic t_word_s();
    run_op(32'hFFFF_8000, 32'd1, 1'b1, 1'b1, "R4 word -32768 fits");
    run_op(32'h0001_0000, 32'd2, 1'b1, 1'b1, "R4 word 32768 ovf");
    run_op(32'h0000_FFFE, 32'hFFFF_FFFE, 1'b1, 1'b1, "R4 word -32767");
  endtask

  task automatic t_minneg();
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7 min/-1 long");
    chk(quot_o == 32'h8000_0000 && rem_o == 0, "R7 fixed value", quot_o, 32'h8000_0000);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, "R7 min/-1 word");
    chk(flags_o == 4'b1010, "R7 word flags", {28'h0, flags_o}, 32'hA);
  endtask

  task automatic t_trap();
    logic [31:0] pq, pr;
    logic [3:0]  pf;
    run_op(32'd1000, 32'd3, 1'b0, 1'b0, "R1 prior op");
    pq = quot_o; pr = rem_o; pf = flags_o;
    launch(32'd55, 32'd0, 1'b1, 1'b1);
    chk(dz_trap_o, "R1 trap raised", {31'h0, dz_trap_o}, 32'h1);
    chk(!busy_o, "R1 no busy on trap", {31'h0, busy_o}, 32'h0);
    chk(quot_o == pq && rem_o == pr, "R1 results held", quot_o, pq);
    chk(flags_o == pf, "R1 flags held", {28'h0, flags_o}, {28'h0, pf});
    @(negedge clk);
    chk(!dz_trap_o && !done_o, "R1 trap one cycle", {30'h0, dz_trap_o, done_o}, 32'h0);
  endtask

  task automatic t_busy_ignore();
    int n;
    bit trap_seen;
    @(negedge clk);
    launch(32'd1000, 32'd3, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    dividend_i = 32'd77; divisor_i = 32'd0; signed_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    dividend_i = 32'd9; divisor_i = 32'd4;
    trap_seen = dz_trap_o;
    chk(!trap_seen, "R9 no trap while busy", {31'h0, dz_trap_o}, 32'h0);
    wait_done(n);
    check_result(32'd1000, 32'd3, 1'b0, 1'b0, n + 5, "R9 run undisturbed");
    repeat (3) @(negedge clk);
    chk(!done_o && !busy_o, "R9 no extra completion", {30'h0, done_o, busy_o}, 32'h0);
  endtask

  task automatic t_back_to_back();
    int n;
    @(negedge clk);
    launch(32'd500, 32'd7, 1'b0, 1'b0);
    wait_done(n);
    check_result(32'd500, 32'd7, 1'b0, 1'b0, n, "R10 first op");
    launch(-32'sd100, 32'd9, 1'b1, 1'b0);
    chk(busy_o, "R10 start in done cycle accepted", {31'h0, busy_o}, 32'h1);
    chk(quot_o == 32'd71, "R10 first result held", quot_o, 32'd71);
    wait_done(n);
    check_result(-32'sd100, 32'd9, 1'b1, 1'b0, n, "R10 second op");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unsigned();
    t_word_u();
    t_signed();
    t_word_s();
    t_minneg();
    t_trap();
    t_busy_ignore();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule